// File: doc/BRIEF.md
# Asynchronous Serial Port with Sticky Status Flags

This block is a full-duplex asynchronous serial port for a small on-chip peripheral bus. Software writes a byte into a transmit holding register and hands it over by clearing a "transmit empty" flag; the port moves the byte into its shifter, sends a frame on `txd`, and raises the flag again so the next byte can be queued while the current one is on the wire. Once the final stop bit has left the pin with nothing queued, a separate "transmit finished" flag is raised.

On the receive side the `rxd` line is synchronised and oversampled sixteen times per bit. A frame is detected on a falling edge, confirmed at the middle of the start bit, and every later bit is taken at its centre. A good frame lands in the receive holding register with a "receive full" flag. Parity, framing and overrun problems raise sticky error flags, and while any of them is set the receiver drops every new frame. Each flag is cleared only by a write of 0 to a flag that software has already read as 1. Each of the four interrupt outputs is its flag ANDed with its enable bit.

Top module: `sci_port`

## Requirements
- R1: A transmitted frame is a 0 start bit, then data bits sent least significant first, then a parity bit if parity is on, then a 1 stop bit. Each bit lasts 16*DIV clock cycles. Even parity makes the count of ones over data plus parity even, and odd parity makes it odd.
- R2: After reset `txd` is 1, the status register reads 0x43 (transmit empty, transmit finished, line level 1), and all interrupt outputs are 0. Between frames `txd` stays at 1.
- R3: When transmit is enabled and transmit empty is 0, the shifter loads the holding register and transmit empty returns to 1 on the next cycle. `irq_txe` equals transmit empty AND its enable.
- R4: Clearing transmit empty also clears transmit finished. Transmit finished is set when a frame's stop bit ends while transmit empty is 1, and `irq_tend` then follows it.
- R5: A received frame with no error, arriving while receive full is 0 and no error flag is set, is stored in the receive data register and sets receive full and `irq_rxf`.
- R6: A received frame whose parity bit does not match the selected parity sets the parity error flag and leaves receive full and the receive data register unchanged.
- R7: A frame that completes while receive full is 1 sets the overrun flag, and its byte is discarded.
- R8: A stop bit sampled as 0 sets the framing error flag. Status bit 6 always shows the synchronised `rxd` level, so a held-low line reads as 0.
- R9: While any error flag is 1, completed frames change neither the receive data register nor receive full. `irq_err` is the OR of the error flags AND its enable.
- R10: A status flag clears only when the flag was read as 1 since the last status write and the write carries 0 in that bit position. Writing 1 has no effect, and neither does writing 0 without that earlier read.
- R11: A low pulse on `rxd` shorter than half a bit is not taken as a start bit and produces no frame.
- R12: The register map is as follows. Address 0 is control: bit0 transmit enable, bit1 receive enable, bit2 parity enable, bit3 odd parity, bit4 to bit7 enables for transmit empty, transmit finished, receive full and receive error. Address 1 is transmit data. Address 2 is receive data. Address 3 is status: bit0 transmit empty, bit1 transmit finished, bit2 receive full, bit3 overrun, bit4 parity error, bit5 framing error, bit6 line level. Reads are combinational while `bus_sel` is 1 and `bus_wr` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| irq_txe | output | 1 | Transmit empty interrupt |
| irq_tend | output | 1 | Transmit finished interrupt |
| irq_rxf | output | 1 | Receive full interrupt |
| irq_err | output | 1 | Receive error interrupt |

## Verification
Bytes 0xA5, 0x3C, 0x00 and 0xFF are sent and received under even parity, odd parity and no parity. This separates a wrong bit order, a wrong parity sense and an off-by-one frame length. One received frame carries an inverted parity bit, which shows whether a bad frame is kept out of the data register. Directed sequences then drive an overrun, a break with a zero stop bit, a half-bit glitch, and flag writes with and without the required earlier read. These show whether the flags are sticky, whether the receiver stays locked while an error is set, and whether writes that should do nothing leave the flags alone.

// File: rtl/sci_pkg.sv
package sci_pkg;

    localparam int OSR     = 16;
    localparam int OSR_W   = $clog2(OSR);
    localparam int MID_CNT = OSR / 2 - 1;

    typedef enum logic [1:0] {
        ADDR_CTRL = 2'd0,
        ADDR_TXD  = 2'd1,
        ADDR_RXD  = 2'd2,
        ADDR_STAT = 2'd3
    } reg_addr_e;

    localparam int FL_TXE  = 0;
    localparam int FL_TEND = 1;
    localparam int FL_RXF  = 2;
    localparam int FL_OVR  = 3;
    localparam int FL_PER  = 4;
    localparam int FL_FER  = 5;
    localparam int NFLAGS  = 6;

    typedef struct packed {
        logic ie_err;
        logic ie_rxf;
        logic ie_tend;
        logic ie_txe;
        logic par_odd;
        logic par_en;
        logic rx_en;
        logic tx_en;
    } ctrl_t;

    typedef struct packed {
        logic [7:0] data;
        logic       perr;
        logic       ferr;
    } rx_frame_t;

    typedef enum logic [2:0] {
        RX_IDLE, RX_START, RX_DATA, RX_PAR, RX_STOP
    } rx_state_e;

    function automatic logic parity_of(input logic [7:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction

endpackage

// File: rtl/sci_baud_tick.sv
module sci_baud_tick #(
    parameter int DIV = 2
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else if (cnt == LAST) begin
            cnt  <= '0;
            tick <= 1'b1;
        end else begin
            cnt  <= cnt + 1'b1;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/sci_tx_shift.sv
module sci_tx_shift
    import sci_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       load,
    input  logic [7:0] data,
    input  logic       par_en,
    input  logic       par_odd,
    output logic       txd,
    output logic       busy,
    output logic       done
);
    logic [10:0]      sh;
    logic [3:0]       bits_left;
    logic [OSR_W-1:0] sub;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh        <= '1;
            bits_left <= '0;
            sub       <= '0;
            busy      <= 1'b0;
            done      <= 1'b0;
            txd       <= 1'b1;
        end else begin
            done <= 1'b0;
            if (load && !busy) begin
                sh        <= {1'b1, par_en ? parity_of(data, par_odd) : 1'b1, data, 1'b0};
                bits_left <= par_en ? 4'd11 : 4'd10;
                sub       <= '0;
                busy      <= 1'b1;
                txd       <= 1'b0;
            end else if (busy && tick) begin
                if (sub == OSR_W'(OSR - 1)) begin
                    sub       <= '0;
                    bits_left <= bits_left - 1'b1;
                    if (bits_left == 4'd1) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                        txd  <= 1'b1;
                    end else begin
                        sh  <= {1'b1, sh[10:1]};
                        txd <= sh[1];
                    end
                end else begin
                    sub <= sub + 1'b1;
                end
            end
        end
    end

    assert_idle_mark_R2: assert property (@(posedge clk) disable iff (rst) !busy |-> txd)
        else $error("txd not at mark while idle");
endmodule

// File: rtl/sci_rx_sample.sv
module sci_rx_sample
    import sci_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      en,
    input  logic      rxd_s,
    input  logic      par_en,
    input  logic      par_odd,
    output logic      done,
    output rx_frame_t frame
);
    rx_state_e        state;
    logic [OSR_W-1:0] sub;
    logic [2:0]       idx;
    logic [7:0]       sh;
    logic             pbit;
    logic             rx_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= RX_IDLE;
            sub     <= '0;
            idx     <= '0;
            sh      <= '0;
            pbit    <= 1'b0;
            rx_prev <= 1'b1;
            done    <= 1'b0;
            frame   <= '0;
        end else begin
            done <= 1'b0;
            if (tick) rx_prev <= rxd_s;
            if (!en) begin
                state <= RX_IDLE;
            end else if (tick) begin
                unique case (state)
                    RX_IDLE: if (rx_prev && !rxd_s) begin
                        state <= RX_START;
                        sub   <= '0;
                    end
                    RX_START: if (sub == OSR_W'(MID_CNT)) begin
                        state <= rxd_s ? RX_IDLE : RX_DATA;
                        sub   <= '0;
                        idx   <= '0;
                    end else begin
                        sub <= sub + 1'b1;
                    end
                    RX_DATA: if (sub == OSR_W'(OSR - 1)) begin
                        sub <= '0;
                        sh  <= {rxd_s, sh[7:1]};
                        idx <= idx + 1'b1;
                        if (idx == 3'd7) state <= par_en ? RX_PAR : RX_STOP;
                    end else begin
                        sub <= sub + 1'b1;
                    end
                    RX_PAR: if (sub == OSR_W'(OSR - 1)) begin
                        sub   <= '0;
                        pbit  <= rxd_s;
                        state <= RX_STOP;
                    end else begin
                        sub <= sub + 1'b1;
                    end
                    RX_STOP: if (sub == OSR_W'(OSR - 1)) begin
                        sub        <= '0;
                        done       <= 1'b1;
                        frame.data <= sh;
                        frame.ferr <= !rxd_s;
                        frame.perr <= par_en && (pbit != parity_of(sh, par_odd));
                        state      <= RX_IDLE;
                    end else begin
                        sub <= sub + 1'b1;
                    end
                    default: state <= RX_IDLE;
                endcase
            end
        end
    end

    assert_start_confirmed_R11: assert property (@(posedge clk) disable iff (rst)
        (state == RX_DATA && $past(state) == RX_START) |-> !$past(rxd_s))
        else $error("start accepted with line high at mid-bit");
endmodule

// File: rtl/sci_port.sv
module sci_port
    import sci_pkg::*;
#(
    parameter int DIV = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    input  logic       rxd,
    output logic       txd,
    output logic       irq_txe,
    output logic       irq_tend,
    output logic       irq_rxf,
    output logic       irq_err
);
    ctrl_t             ctrl;
    logic [7:0]        tdr, rdr;
    logic [NFLAGS-1:0] flags, seen, clr;
    logic              rx_m, rx_s;
    logic              tick, load, tx_busy, tx_done, rx_done;
    rx_frame_t         rx_frame;
    logic              rd_stat, wr_stat, err_any;

    assign rd_stat = bus_sel && !bus_wr && bus_addr == ADDR_STAT;
    assign wr_stat = bus_sel && bus_wr && bus_addr == ADDR_STAT;
    assign clr     = wr_stat ? (seen & ~bus_wdata[NFLAGS-1:0]) : '0;
    assign err_any = flags[FL_OVR] | flags[FL_PER] | flags[FL_FER];
    assign load    = ctrl.tx_en && !flags[FL_TXE] && !tx_busy;

    sci_baud_tick #(.DIV(DIV)) tick_i (.clk(clk), .rst(rst), .tick(tick));

    sci_tx_shift tx_i (
        .clk(clk), .rst(rst), .tick(tick), .load(load), .data(tdr),
        .par_en(ctrl.par_en), .par_odd(ctrl.par_odd),
        .txd(txd), .busy(tx_busy), .done(tx_done)
    );

    sci_rx_sample rx_i (
        .clk(clk), .rst(rst), .tick(tick), .en(ctrl.rx_en), .rxd_s(rx_s),
        .par_en(ctrl.par_en), .par_odd(ctrl.par_odd),
        .done(rx_done), .frame(rx_frame)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rx_m  <= 1'b1;
            rx_s  <= 1'b1;
            ctrl  <= '0;
            tdr   <= '0;
            rdr   <= '0;
            flags <= NFLAGS'(1 << FL_TXE | 1 << FL_TEND);
            seen  <= '0;
        end else begin
            rx_m <= rxd;
            rx_s <= rx_m;
            if (bus_sel && bus_wr && bus_addr == ADDR_CTRL) ctrl <= ctrl_t'(bus_wdata);
            if (bus_sel && bus_wr && bus_addr == ADDR_TXD)  tdr  <= bus_wdata;

            if (wr_stat)      seen <= '0;
            else if (rd_stat) seen <= seen | flags;
            else              seen <= seen & flags;

            flags <= flags & ~clr;
            if (clr[FL_TXE]) flags[FL_TEND] <= 1'b0;
            if (load)        flags[FL_TXE]  <= 1'b1;
            if (tx_done && flags[FL_TXE] && !clr[FL_TXE]) flags[FL_TEND] <= 1'b1;

            if (rx_done && !err_any) begin
                if (flags[FL_RXF]) begin
                    flags[FL_OVR] <= 1'b1;
                end else if (rx_frame.perr || rx_frame.ferr) begin
                    if (rx_frame.perr) flags[FL_PER] <= 1'b1;
                    if (rx_frame.ferr) flags[FL_FER] <= 1'b1;
                end else begin
                    rdr           <= rx_frame.data;
                    flags[FL_RXF] <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && !bus_wr) begin
            unique case (reg_addr_e'(bus_addr))
                ADDR_CTRL: bus_rdata = ctrl;
                ADDR_TXD:  bus_rdata = tdr;
                ADDR_RXD:  bus_rdata = rdr;
                ADDR_STAT: bus_rdata = {1'b0, rx_s, flags};
                default:   bus_rdata = '0;
            endcase
        end
    end

    assign irq_txe  = flags[FL_TXE]  & ctrl.ie_txe;
    assign irq_tend = flags[FL_TEND] & ctrl.ie_tend;
    assign irq_rxf  = flags[FL_RXF]  & ctrl.ie_rxf;
    assign irq_err  = err_any        & ctrl.ie_err;

    assert_txe_on_load_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FL_TXE]) |-> $past(load))
        else $error("transmit empty rose without a shifter load");
    assert_tend_needs_txe_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FL_TEND]) |-> flags[FL_TXE])
        else $error("transmit finished set while a byte is queued");
    assert_rxf_from_frame_R5: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FL_RXF]) |-> $past(rx_done))
        else $error("receive full rose without a frame");
    assert_ovr_cause_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(flags[FL_OVR]) |-> $past(rx_done && flags[FL_RXF]))
        else $error("overrun without a frame on a full register");
    assert_hold_on_err_R9: assert property (@(posedge clk) disable iff (rst)
        (rx_done && err_any) |=> $stable(rdr))
        else $error("receive data changed while an error was pending");
    assert_clear_needs_read_R10: assert property (@(posedge clk) disable iff (rst)
        $fell(flags[FL_RXF]) |-> $past(wr_stat && seen[FL_RXF] && !bus_wdata[FL_RXF]))
        else $error("receive full cleared without read-then-write-zero");
endmodule

// File: tb/sci_port_tb.sv
module sci_port_tb_top;
    localparam int DIV = 2;
    localparam int BIT = 16 * DIV;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       rxd = 1'b1;
    logic       txd, irq_txe, irq_tend, irq_rxf, irq_err;

    int checks = 0;
    int errs   = 0;

    always #2 clk = ~clk;

    sci_port #(.DIV(DIV)) dut_i (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rxd(rxd), .txd(txd), .irq_txe(irq_txe), .irq_tend(irq_tend),
        .irq_rxf(irq_rxf), .irq_err(irq_err)
    );

    // {data[7:0], parity enable, odd parity, corrupt parity on receive}
    localparam logic [10:0] VEC [0:3] = '{
        {8'hA5, 3'b100},
        {8'h3C, 3'b110},
        {8'h00, 3'b000},
        {8'hFF, 3'b111}
    };

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic clear_flag(input int b);
        logic [7:0] s;
        rd(2'd3, s);
        wr(2'd3, 8'hFF & ~(8'd1 << b));
    endtask

    task automatic send_rx(input logic [7:0] d, input logic pen, input logic podd,
                           input logic badpar, input logic stopv);
        logic p;
        p = (^d) ^ podd ^ badpar;
        @(negedge clk);
        rxd = 1'b0;
        repeat (BIT) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = d[i];
            repeat (BIT) @(negedge clk);
        end
        if (pen) begin
            rxd = p;
            repeat (BIT) @(negedge clk);
        end
        rxd = stopv;
        repeat (BIT) @(negedge clk);
        if (stopv) repeat (4) @(negedge clk);
    endtask

    task automatic capture_tx(input int n, output logic [10:0] bits);
        bits = '0;
        @(negedge clk);
        while (txd) @(negedge clk);
        repeat (BIT / 2) @(negedge clk);
        bits[0] = txd;
        for (int i = 1; i < n; i++) begin
            repeat (BIT) @(negedge clk);
            bits[i] = txd;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errs++;
        $display("FAIL watchdog: actual=timeout expected=done");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        logic [7:0]  s, d, ctl;
        logic [10:0] bits;
        logic [7:0]  vd;
        logic        pen, podd, bad, p;
        int          n;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R2: reset state
        chk("R2 txd after reset", txd, 1);
        rd(2'd3, s);
        chk("R2 status after reset", s, 8'h43);
        chk("R2 irqs after reset", {irq_txe, irq_tend, irq_rxf, irq_err}, 0);

        // R12: control register readback
        wr(2'd0, 8'hF3);
        rd(2'd0, s);
        chk("R12 control readback", s, 8'hF3);

        // Table walk: transmit and receive each vector
        for (int v = 0; v < 4; v++) begin
            vd = VEC[v][10:3]; pen = VEC[v][2]; podd = VEC[v][1]; bad = VEC[v][0];
            p = (^vd) ^ podd;
            n = pen ? 11 : 10;
            ctl = {4'hF, podd, pen, 2'b11};
            wr(2'd0, ctl);
            fork
                capture_tx(n, bits);
                begin
                    wr(2'd1, vd);
                    clear_flag(0);
                    rd(2'd3, s);
                    chk("R3 transmit empty back after load", s[0], 1);
                    chk("R4 finished cleared with empty", s[1], 0);
                    chk("R3 irq_txe follows flag", irq_txe, 1);
                end
            join
            chk("R1 start bit", bits[0], 0);
            chk("R1 data bits LSB first", bits[8:1], vd);
            if (pen) chk("R1 parity bit", bits[9], p);
            chk("R1 stop bit", bits[n-1], 1);
            repeat (BIT) @(negedge clk);
            chk("R2 line idles at mark", txd, 1);
            rd(2'd3, s);
            chk("R4 transmit finished after stop", s[1:0], 2'b11);
            chk("R4 irq_tend", irq_tend, 1);

            send_rx(vd, pen, podd, bad, 1'b1);
            rd(2'd3, s);
            if (bad) begin
                chk("R6 parity error flag", s[4], 1);
                chk("R6 no receive full on bad parity", s[2], 0);
                chk("R9 irq_err on parity error", irq_err, 1);
                clear_flag(4);
                rd(2'd3, s);
                chk("R10 parity error cleared", s[4], 0);
            end else begin
                chk("R5 receive full", s[2], 1);
                chk("R5 irq_rxf", irq_rxf, 1);
                rd(2'd2, d);
                chk("R5 received byte", d, vd);
                clear_flag(2);
                rd(2'd3, s);
                chk("R10 receive full cleared", s[2], 0);
            end
        end

        // R10: clearing rules
        wr(2'd0, 8'hF7);
        send_rx(8'h5A, 1'b1, 1'b0, 1'b0, 1'b1);
        wr(2'd3, 8'hFB);
        rd(2'd3, s);
        chk("R10 write 0 without read ignored", s[2], 1);
        wr(2'd3, 8'hFF);
        rd(2'd3, s);
        chk("R10 write 1 ignored", s[2], 1);
        wr(2'd3, 8'hFB);
        rd(2'd3, s);
        chk("R10 read then write 0 clears", s[2], 0);

        // R7: overrun
        send_rx(8'h11, 1'b1, 1'b0, 1'b0, 1'b1);
        send_rx(8'h22, 1'b1, 1'b0, 1'b0, 1'b1);
        rd(2'd3, s);
        chk("R7 overrun flag", s[3], 1);
        rd(2'd2, d);
        chk("R7 second byte discarded", d, 8'h11);
        clear_flag(2);

        // R9: locked while error pending
        send_rx(8'h33, 1'b1, 1'b0, 1'b0, 1'b1);
        rd(2'd3, s);
        chk("R9 no receive full while error set", s[2], 0);
        rd(2'd2, d);
        chk("R9 data register held", d, 8'h11);
        clear_flag(3);
        send_rx(8'h44, 1'b1, 1'b0, 1'b0, 1'b1);
        rd(2'd2, d);
        chk("R9 accepts after clearing", d, 8'h44);
        clear_flag(2);

        // R8: framing error and break level
        send_rx(8'h66, 1'b1, 1'b0, 1'b0, 1'b0);
        repeat (4) @(negedge clk);
        rd(2'd3, s);
        chk("R8 framing error flag", s[5], 1);
        chk("R8 line level reads low", s[6], 0);
        chk("R9 irq_err on framing error", irq_err, 1);
        rxd = 1'b1;
        repeat (BIT) @(negedge clk);
        rd(2'd3, s);
        chk("R8 line level reads high", s[6], 1);
        clear_flag(5);

        // R11: short glitch
        @(negedge clk);
        rxd = 1'b0;
        repeat (BIT / 4) @(negedge clk);
        rxd = 1'b1;
        repeat (BIT * 12) @(negedge clk);
        rd(2'd3, s);
        chk("R11 glitch gives no frame", s[5:2], 4'b0000);
        send_rx(8'h81, 1'b1, 1'b0, 1'b0, 1'b1);
        rd(2'd2, d);
        chk("R11 receiver still works", d, 8'h81);

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule